// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load Stall Unit

This combinational block sits beside the decode stage of a five-stage 32-bit pipeline in which register operands are resolved during decode. For each of the two source registers of the decoding instruction, it picks the operand's origin. The origin is either the register file read port or the result held by the instruction in EX, MEM or WB. Each producer is described by its destination register number, its register-write flag and its memory-read (load) flag.

Two cases cannot be served by forwarding. One is a load in EX or MEM whose destination feeds the decoding instruction, because load data exists only once the load reaches WB. In those cases the unit raises a stall. The stall holds the program counter and the fetch/decode register, and turns the instruction entering EX into a bubble. WB is itself a forwarding source because the register file shows a written value at its read port only one cycle after the write.

Top module: `fwd_unit`

## Requirements
- R1: Select codes are 0 for the register file, 1 for the EX result, 2 for the MEM result and 3 for the WB result. The rs select follows instruction bits 25-21 and the rt select follows bits 20-16, each 5 bits wide.
- R2: A stage is a forwarding candidate for a source only when its register-write flag is 1 and its destination equals that source number.
- R3: A producer whose destination is register 0 is never selected, so a source of 0 always yields select 0.
- R4: When several stages match a source, the newest wins: EX before MEM, MEM before WB, and WB before the register file.
- R5: The two sources are resolved independently and may receive different selects in the same cycle.
- R6: A matching writer in WB with no newer match gives select 3, because register file data written in WB is not readable until the next cycle.
- R7: A load (write flag 1, load flag 1, destination nonzero) in MEM whose destination equals either source raises stall.
- R8: A load in EX whose destination equals either source raises stall.
- R9: While stall is 1, pc_we and ifid_we are 0 and ex_bubble is 1. Otherwise pc_we and ifid_we are 1 and ex_bubble is 0.
- R10: A load flag without the write flag, a load with destination 0, a load in WB, and a load matching no source do not raise stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register number of the decoding instruction |
| id_rt | input | 5 | Second source register number of the decoding instruction |
| ex_dst | input | 5 | Destination register of the instruction in EX |
| ex_wr | input | 1 | Register-write flag of the instruction in EX |
| ex_load | input | 1 | Memory-read flag of the instruction in EX |
| mem_dst | input | 5 | Destination register of the instruction in MEM |
| mem_wr | input | 1 | Register-write flag of the instruction in MEM |
| mem_load | input | 1 | Memory-read flag of the instruction in MEM |
| wb_dst | input | 5 | Destination register of the instruction in WB |
| wb_wr | input | 1 | Register-write flag of the instruction in WB |
| wb_load | input | 1 | Memory-read flag of the instruction in WB |
| sel_rs | output | 2 | Operand origin select for the rs source |
| sel_rt | output | 2 | Operand origin select for the rt source |
| stall | output | 1 | Load-use hazard detected |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_bubble | output | 1 | Clear the control write flags of the instruction entering EX |

## Verification
Single-producer patterns put one writer in each stage in turn and show that each select code maps to the right stage. Overlap patterns place the same destination in two or three stages, which separates a correct priority order from a reversed one. Split patterns give rs and rt different matches, and register-0 and write-flag-off patterns show that non-writers are ignored. Load patterns in EX, MEM and WB, with and without a match, separate true load-use hazards from false stalls. A long pseudo-random sweep over a small register range, which forces frequent collisions, is compared against a reference model written from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_AW   = 5;
    localparam int NUM_PROD = 3;   // EX, MEM, WB in priority order
    localparam int NUM_SRC  = 2;   // rs, rt
    localparam int SEL_W    = $clog2(NUM_PROD + 1);
    localparam int LOAD_WIN = 2;   // stages whose load data is not yet available

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } fwd_sel_e;

    typedef struct packed {
        reg_idx_t dst;
        logic     wr;
        logic     load;
    } producer_t;

    // True when a producer writes a nonzero register equal to the source.
    function automatic logic producer_hits(producer_t p, reg_idx_t src);
        return p.wr && (p.dst == src) && (p.dst != '0);
    endfunction

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  reg_idx_t                 src_reg,
    input  producer_t [NUM_PROD-1:0] prods,
    output fwd_sel_e                 sel
);

    logic [SEL_W-1:0] pick;

    // Walk from oldest to newest so the newest match overrides.
    always_comb begin
        pick = '0;
        for (int i = NUM_PROD - 1; i >= 0; i--) begin
            if (producer_hits(prods[i], src_reg))
                pick = SEL_W'(i + 1);
        end
    end

    assign sel = fwd_sel_e'(pick);

    always_comb begin
        // R3: source 0 is always served by the register file
        if (src_reg == '0)
            a_r3_zero_never_forwarded: assert (sel == SEL_RF);
        // R4: an EX writer that matches takes precedence over older stages
        if (prods[0].wr && prods[0].dst == src_reg && src_reg != '0)
            a_r4_ex_wins: assert (sel == SEL_EX);
        // R2: a WB select requires a WB writer to that register
        if (sel == SEL_WB)
            a_r2_wb_needs_write: assert (prods[2].wr && prods[2].dst == src_reg);
    end

endmodule

// File: rtl/fwd_load_hazard.sv
module fwd_load_hazard
    import fwd_pkg::*;
(
    input  reg_idx_t  [NUM_SRC-1:0]  srcs,
    input  producer_t [NUM_PROD-1:0] prods,
    output logic                     hazard
);

    logic [LOAD_WIN-1:0][NUM_SRC-1:0] hit_mx;

    genvar gs, gp;
    generate
        for (gp = 0; gp < LOAD_WIN; gp++) begin : g_stage
            for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
                assign hit_mx[gp][gs] = prods[gp].load
                                      && producer_hits(prods[gp], srcs[gs]);
            end
        end
    endgenerate

    assign hazard = |hit_mx;

    always_comb begin
        // R7: a matching load in MEM must stall
        if (prods[1].load && prods[1].wr && prods[1].dst != '0
            && (prods[1].dst == srcs[0] || prods[1].dst == srcs[1]))
            a_r7_mem_load_stalls: assert (hazard);
        // R10: no load inside the window means no stall
        if (!prods[0].load && !prods[1].load)
            a_r10_no_load_no_stall: assert (!hazard);
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [4:0] id_rs,
    input  logic [4:0] id_rt,
    input  logic [4:0] ex_dst,
    input  logic       ex_wr,
    input  logic       ex_load,
    input  logic [4:0] mem_dst,
    input  logic       mem_wr,
    input  logic       mem_load,
    input  logic [4:0] wb_dst,
    input  logic       wb_wr,
    input  logic       wb_load,
    output logic [1:0] sel_rs,
    output logic [1:0] sel_rt,
    output logic       stall,
    output logic       pc_we,
    output logic       ifid_we,
    output logic       ex_bubble
);

    producer_t [NUM_PROD-1:0] prods;
    reg_idx_t  [NUM_SRC-1:0]  srcs;
    fwd_sel_e  [NUM_SRC-1:0]  sels;
    logic                     hazard;

    assign prods[0] = '{dst: ex_dst,  wr: ex_wr,  load: ex_load};
    assign prods[1] = '{dst: mem_dst, wr: mem_wr, load: mem_load};
    assign prods[2] = '{dst: wb_dst,  wr: wb_wr,  load: wb_load};
    assign srcs[0]  = id_rs;
    assign srcs[1]  = id_rt;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_operand
            fwd_operand_sel u_sel (
                .src_reg (srcs[g]),
                .prods   (prods),
                .sel     (sels[g])
            );
        end
    endgenerate

    fwd_load_hazard u_haz (
        .srcs   (srcs),
        .prods  (prods),
        .hazard (hazard)
    );

    assign sel_rs    = sels[0];
    assign sel_rt    = sels[1];
    assign stall     = hazard;
    assign pc_we     = !hazard;
    assign ifid_we   = !hazard;
    assign ex_bubble = hazard;

    always_comb begin
        // R9: a stall freezes fetch and decode and issues a bubble
        a_r9_stall_controls: assert (stall ? (!pc_we && !ifid_we && ex_bubble)
                                           : (pc_we && ifid_we && !ex_bubble));
        // R8: a matching load in EX must stall
        if (ex_load && ex_wr && ex_dst != '0 && (ex_dst == id_rs || ex_dst == id_rt))
            a_r8_ex_load_stalls: assert (stall);
    end

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [4:0] id_rs, id_rt, ex_dst, mem_dst, wb_dst;
    logic       ex_wr, ex_load, mem_wr, mem_load, wb_wr, wb_load;
    logic [1:0] sel_rs, sel_rt;
    logic       stall, pc_we, ifid_we, ex_bubble;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    fwd_unit u_dut (
        .id_rs(id_rs), .id_rt(id_rt),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_load(wb_load),
        .sel_rs(sel_rs), .sel_rt(sel_rt), .stall(stall),
        .pc_we(pc_we), .ifid_we(ifid_we), .ex_bubble(ex_bubble)
    );

    // Reference model written from the requirements.
    function automatic logic [1:0] ref_sel(logic [4:0] s);
        if (s == 5'd0) return 2'd0;
        if (ex_wr && ex_dst == s) return 2'd1;
        if (mem_wr && mem_dst == s) return 2'd2;
        if (wb_wr && wb_dst == s) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic ref_stall();
        logic r = 1'b0;
        if (ex_load && ex_wr && ex_dst != 0 && (ex_dst == id_rs || ex_dst == id_rt)) r = 1'b1;
        if (mem_load && mem_wr && mem_dst != 0 && (mem_dst == id_rs || mem_dst == id_rt)) r = 1'b1;
        return r;
    endfunction

    task automatic clear_all();
        id_rs = 0; id_rt = 0;
        ex_dst = 0; ex_wr = 0; ex_load = 0;
        mem_dst = 0; mem_wr = 0; mem_load = 0;
        wb_dst = 0; wb_wr = 0; wb_load = 0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, {6'd0, sel_rs}, {6'd0, ref_sel(id_rs)});
        check(req, {6'd0, sel_rt}, {6'd0, ref_sel(id_rt)});
        check(req, {4'd0, stall, pc_we, ifid_we, ex_bubble},
              {4'd0, ref_stall(), !ref_stall(), !ref_stall(), ref_stall()});
    endtask

    task automatic t_idle();
        clear_all(); id_rs = 5'd7; id_rt = 5'd9; settle();
        check("R1 idle rs", {6'd0, sel_rs}, 8'd0);
        check("R1 idle rt", {6'd0, sel_rt}, 8'd0);
        check("R9 idle ctl", {5'd0, pc_we, ifid_we, ex_bubble}, 8'b110);
    endtask

    task automatic t_single_stage();
        clear_all(); id_rs = 5'd4; id_rt = 5'd20;
        ex_dst = 5'd4; ex_wr = 1; settle();
        check("R1 ex code", {6'd0, sel_rs}, 8'd1);
        clear_all(); id_rs = 5'd4; id_rt = 5'd20;
        mem_dst = 5'd20; mem_wr = 1; settle();
        check("R1 mem code", {6'd0, sel_rt}, 8'd2);
        clear_all(); id_rs = 5'd4; id_rt = 5'd20;
        wb_dst = 5'd4; wb_wr = 1; settle();
        check("R6 wb code", {6'd0, sel_rs}, 8'd3);
    endtask

    task automatic t_no_write();
        clear_all(); id_rs = 5'd11; id_rt = 5'd11;
        ex_dst = 5'd11; mem_dst = 5'd11; wb_dst = 5'd11; settle();
        check("R2 no write flags", {6'd0, sel_rs}, 8'd0);
        mem_wr = 1; settle();
        check("R2 only mem writes", {6'd0, sel_rt}, 8'd2);
    endtask

    task automatic t_zero_reg();
        clear_all();
        ex_wr = 1; mem_wr = 1; wb_wr = 1; settle();
        check("R3 zero rs", {6'd0, sel_rs}, 8'd0);
        check("R3 zero rt", {6'd0, sel_rt}, 8'd0);
    endtask

    task automatic t_priority();
        clear_all(); id_rs = 5'd6; id_rt = 5'd6;
        ex_dst = 5'd6; mem_dst = 5'd6; wb_dst = 5'd6;
        ex_wr = 1; mem_wr = 1; wb_wr = 1; settle();
        check("R4 ex over all", {6'd0, sel_rs}, 8'd1);
        ex_wr = 0; settle();
        check("R4 mem over wb", {6'd0, sel_rs}, 8'd2);
        mem_wr = 0; settle();
        check("R4 wb over rf", {6'd0, sel_rt}, 8'd3);
    endtask

    task automatic t_independent();
        clear_all(); id_rs = 5'd3; id_rt = 5'd5;
        ex_dst = 5'd5; ex_wr = 1; wb_dst = 5'd3; wb_wr = 1; settle();
        check("R5 rs from wb", {6'd0, sel_rs}, 8'd3);
        check("R5 rt from ex", {6'd0, sel_rt}, 8'd1);
    endtask

    task automatic t_loads();
        clear_all(); id_rs = 5'd2; id_rt = 5'd8;
        mem_dst = 5'd8; mem_wr = 1; mem_load = 1; settle();
        check("R7 mem load stall", {7'd0, stall}, 8'd1);
        check("R9 stall ctl", {5'd0, pc_we, ifid_we, ex_bubble}, 8'b001);
        clear_all(); id_rs = 5'd2; id_rt = 5'd8;
        ex_dst = 5'd2; ex_wr = 1; ex_load = 1; settle();
        check("R8 ex load stall", {7'd0, stall}, 8'd1);
        clear_all(); id_rs = 5'd2; id_rt = 5'd8;
        wb_dst = 5'd2; wb_wr = 1; wb_load = 1; settle();
        check("R10 wb load no stall", {7'd0, stall}, 8'd0);
        check("R6 wb load forwarded", {6'd0, sel_rs}, 8'd3);
        clear_all(); id_rs = 5'd2; id_rt = 5'd8;
        mem_dst = 5'd8; mem_load = 1; settle();
        check("R10 load without write", {7'd0, stall}, 8'd0);
        clear_all(); id_rs = 5'd2; id_rt = 5'd8;
        ex_wr = 1; ex_load = 1; settle();
        check("R10 load to r0", {7'd0, stall}, 8'd0);
        ex_dst = 5'd9; settle();
        check("R10 load no match", {7'd0, stall}, 8'd0);
    endtask

    task automatic t_sweep();
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            id_rs = {3'd0, lfsr[1:0]};   id_rt = {3'd0, lfsr[3:2]};
            ex_dst = {3'd0, lfsr[5:4]};  mem_dst = {3'd0, lfsr[7:6]};
            wb_dst = {3'd0, lfsr[9:8]};
            ex_wr = lfsr[10]; ex_load = lfsr[11];
            mem_wr = lfsr[12]; mem_load = lfsr[13];
            wb_wr = lfsr[14]; wb_load = lfsr[15];
            settle();
            check_all("R4 R5 R7 R8 sweep");
        end
    endtask

    initial begin
        fork
            begin
                clear_all();
                repeat (2) @(negedge clk);
                t_idle();
                t_single_stage();
                t_no_write();
                t_zero_reg();
                t_priority();
                t_independent();
                t_loads();
                t_sweep();
                done = 1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    checks++; failures++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule